// File: doc/BRIEF.md
# Paged Flash Read-Modify-Write Sequencer

This block sits on the host side of a serial flash link and turns one "patch these bytes of that page" request into the full command sequence that a page-organized flash with on-chip SRAM buffers needs. The sequence has three steps. It copies the target page into one of two device buffers. It writes the replacement bytes into that buffer at the requested offset. It then commands the device to erase and program the buffer back into the same page. Each array step is self-timed, so the block reads the device status after the copy and after the program, and it keeps reading until the ready bit is set.

The block drives a byte-level SPI engine through a simple handshake. The block issues one byte with a single-cycle start strobe. The engine answers with a single-cycle done strobe that carries the byte shifted in. The block drives the chip-select line itself. It takes the replacement bytes from a valid/ready stream in offset order. A request carries an 11-bit page number, a 9-bit byte offset, a 9-bit length and a buffer select. The block accepts a request only while it is idle, reports success with a one-cycle done pulse, and raises a sticky error flag when the status poll runs out of attempts.

Top module: `flash_rmw_seq`

## Requirements
- R1: While reset is asserted and after it is released, chip select is high (deselected), and start, done, error, busy and stream ready are all low.
- R2: A request is accepted only in the idle state, and busy is high from the cycle after acceptance until the sequence ends. A request presented while busy is ignored: it starts no frame and changes no page.
- R3: The first frame carries four bytes. The opcode is 0x53 for buffer 0 or 0x55 for buffer 1. The address bytes follow as {4'b0, page[10:7]}, then {page[6:0], 1'b0}, then 8'h00.
- R4: After the copy, and again after the program, the block sends a frame that starts with opcode 0x57. It follows the opcode with 0x00 filler bytes and ends the frame after the first received byte whose bit 7 is 1 (ready).
- R5: The buffer-write frame sends opcode 0x84 for buffer 0 or 0x87 for buffer 1. The address bytes are 8'h00, {7'b0, offset[8]} and offset[7:0]. Then come exactly length stream bytes in stream order. Stream ready is high only while the data bytes of this frame are being sent.
- R6: The program frame sends opcode 0x83 for buffer 0 or 0x86 for buffer 1, with the same address packing as R3. It starts only after chip select has risen at the end of the buffer-write frame.
- R7: Chip select stays high for at least GAP_CYCLES cycles between frames of one sequence, and for at least one cycle between two sequences.
- R8: A sequence that succeeds produces exactly one done pulse, one cycle wide. The pulse comes with chip select high and busy low.
- R9: If POLL_LIMIT consecutive status bytes all report busy, the block raises the error flag and returns to idle without a done pulse. The flag stays set until the next request is accepted.
- R10: At most one byte is outstanding at the SPI engine. Start is a one-cycle pulse and occurs only while chip select is low.
- R11: After a successful sequence, the target page holds the replacement bytes at offset..offset+length-1 and its original bytes everywhere else. Other pages are unchanged.
- R12: A length of zero produces a buffer-write frame of exactly the four header bytes. The page is then programmed back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_page | input | PAGE_W | Target page number |
| req_offset | input | BYTE_W | First byte to replace within the page |
| req_len | input | BYTE_W | Number of replacement bytes |
| req_buf | input | 1 | Device buffer select (0 or 1) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err_timeout | output | 1 | Sticky status-poll timeout flag |
| din_valid | input | 1 | Replacement byte available |
| din_data | input | 8 | Replacement byte |
| din_ready | output | 1 | Replacement byte taken this cycle when valid |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_start | output | 1 | Byte exchange request to SPI engine |
| spi_tx | output | 8 | Byte to shift out |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte shifted in, valid with spi_done |

## Verification
The bench sweeps both buffers over pages whose high and low address fields differ. It covers offsets at the start, middle, end and across the bit-8 boundary, and lengths of zero, one and a full tail run. Opcode checks separate the two buffers, and the address-byte checks catch misplaced page or offset bits. The modelled busy time ranges from zero to several status bytes, and the stream is fed both continuously and with gaps. This separates correct poll termination and stream pacing from off-by-one byte counts. A poll that never reports ready, and a request raised mid-sequence, exercise the timeout and ignore paths. Each is followed by a normal sequence to show recovery.

// File: rtl/flash_rmw_pkg.sv
package flash_rmw_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOAD,
      ST_GAP_LOAD,
      ST_POLL_LOAD,
      ST_GAP_POLL,
      ST_WRITE,
      ST_GAP_WRITE,
      ST_PROG,
      ST_GAP_PROG,
      ST_POLL_PROG
   } seq_state_t;

   localparam logic [7:0] OPC_LOAD_B0   = 8'h53;
   localparam logic [7:0] OPC_LOAD_B1   = 8'h55;
   localparam logic [7:0] OPC_WRITE_B0  = 8'h84;
   localparam logic [7:0] OPC_WRITE_B1  = 8'h87;
   localparam logic [7:0] OPC_PROG_B0   = 8'h83;
   localparam logic [7:0] OPC_PROG_B1   = 8'h86;
   localparam logic [7:0] OPC_STATUS    = 8'h57;
   localparam logic [7:0] FILLER_BYTE   = 8'h00;

   localparam int HDR_BYTES  = 4;
   localparam int ADDR_BITS  = 24;
   localparam int READY_BIT  = 7;

   function automatic logic [7:0] pick_opcode(input seq_state_t st, input logic sel);
      logic [7:0] r;
      case (st)
         ST_LOAD:  r = sel ? OPC_LOAD_B1  : OPC_LOAD_B0;
         ST_WRITE: r = sel ? OPC_WRITE_B1 : OPC_WRITE_B0;
         ST_PROG:  r = sel ? OPC_PROG_B1  : OPC_PROG_B0;
         default:  r = OPC_STATUS;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rmw_addr_pack.sv
module rmw_addr_pack import flash_rmw_pkg::*; #(
   parameter int PAGE_W = 11,
   parameter int BYTE_W = 9
) (
   input  logic [PAGE_W-1:0]    page,
   input  logic [BYTE_W-1:0]    offset,
   output logic [ADDR_BITS-1:0] addr
);
   localparam int PAD_W = ADDR_BITS - PAGE_W - BYTE_W;

   generate
      if (PAD_W < 0) begin : g_bad_width
         $error("page and byte fields exceed the three address bytes");
      end
      if (PAD_W > 0) begin : g_padded
         assign addr = {{PAD_W{1'b0}}, page, offset};
      end else begin : g_exact
         assign addr = {page, offset};
      end
   endgenerate
endmodule

// File: rtl/rmw_poll_watch.sv
module rmw_poll_watch #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic last_try
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("poll limit must be at least one");
      end
   endgenerate

   logic [CW-1:0] tries_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tries_q <= '0;
      else if (clear)  tries_q <= '0;
      else if (tick)   tries_q <= tries_q + 1'b1;
   end

   assign last_try = (tries_q == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_rmw_seq.sv
module flash_rmw_seq import flash_rmw_pkg::*; #(
   parameter int PAGE_W     = 11,
   parameter int BYTE_W     = 9,
   parameter int POLL_LIMIT = 4096,
   parameter int GAP_CYCLES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [PAGE_W-1:0] req_page,
   input  logic [BYTE_W-1:0] req_offset,
   input  logic [BYTE_W-1:0] req_len,
   input  logic              req_buf,
   output logic              busy,
   output logic              done,
   output logic              err_timeout,
   input  logic              din_valid,
   input  logic [7:0]        din_data,
   output logic              din_ready,
   output logic              spi_cs_n,
   output logic              spi_start,
   output logic [7:0]        spi_tx,
   input  logic              spi_done,
   input  logic [7:0]        spi_rx
);
   localparam int CNT_W = BYTE_W + 2;
   localparam int GAP_W = $clog2(GAP_CYCLES + 1);

   generate
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("chip-select gap must be at least one cycle");
      end
   endgenerate

   seq_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [GAP_W-1:0]  gap_q;
   logic              inflight_q;
   logic [PAGE_W-1:0] page_q;
   logic [BYTE_W-1:0] off_q;
   logic [BYTE_W-1:0] len_q;
   logic              buf_q;
   logic              done_q;
   logic              err_q;
   logic              start_q;
   logic [7:0]        tx_q;

   logic [ADDR_BITS-1:0] addr_page;
   logic [ADDR_BITS-1:0] addr_off;

   rmw_addr_pack #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_pack_page (
      .page   (page_q),
      .offset ('0),
      .addr   (addr_page)
   );

   rmw_addr_pack #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_pack_off (
      .page   ('0),
      .offset (off_q),
      .addr   (addr_off)
   );

   logic in_frame, in_gap, is_poll, data_phase, hdr_last, write_last;
   logic issue, byte_done, status_ready, poll_last, gap_last;
   logic [ADDR_BITS-1:0] addr_sel;
   logic [7:0] hdr_b, next_b;

   always_comb begin
      in_frame = (state_q == ST_LOAD) || (state_q == ST_POLL_LOAD) ||
                 (state_q == ST_WRITE) || (state_q == ST_PROG) ||
                 (state_q == ST_POLL_PROG);
      in_gap   = (state_q == ST_GAP_LOAD) || (state_q == ST_GAP_POLL) ||
                 (state_q == ST_GAP_WRITE) || (state_q == ST_GAP_PROG);
      is_poll  = (state_q == ST_POLL_LOAD) || (state_q == ST_POLL_PROG);
      data_phase = (state_q == ST_WRITE) && (cnt_q >= CNT_W'(HDR_BYTES));
      hdr_last   = (cnt_q == CNT_W'(HDR_BYTES - 1));
      write_last = ((cnt_q + 1'b1) == (CNT_W'(HDR_BYTES) + CNT_W'(len_q)));
      gap_last   = (gap_q == GAP_W'(GAP_CYCLES - 1));
      issue      = in_frame && !inflight_q && (!data_phase || din_valid);
      byte_done  = in_frame && inflight_q && spi_done;
      status_ready = spi_rx[READY_BIT];

      addr_sel = (state_q == ST_WRITE) ? addr_off : addr_page;
      case (cnt_q[1:0])
         2'd1:    hdr_b = addr_sel[23:16];
         2'd2:    hdr_b = addr_sel[15:8];
         default: hdr_b = addr_sel[7:0];
      endcase

      if (cnt_q == '0)     next_b = pick_opcode(state_q, buf_q);
      else if (is_poll)    next_b = FILLER_BYTE;
      else if (data_phase) next_b = din_data;
      else                 next_b = hdr_b;
   end

   rmw_poll_watch #(.LIMIT(POLL_LIMIT)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!is_poll),
      .tick     (byte_done && is_poll && (cnt_q != '0) && !status_ready),
      .last_try (poll_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         gap_q      <= '0;
         inflight_q <= 1'b0;
         page_q     <= '0;
         off_q      <= '0;
         len_q      <= '0;
         buf_q      <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
         start_q    <= 1'b0;
         tx_q       <= '0;
      end else begin
         done_q  <= 1'b0;
         start_q <= 1'b0;
         if (issue) begin
            start_q    <= 1'b1;
            tx_q       <= next_b;
            inflight_q <= 1'b1;
         end
         if (byte_done) inflight_q <= 1'b0;

         if (in_gap) begin
            if (gap_last) gap_q <= '0;
            else          gap_q <= gap_q + 1'b1;
         end

         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  page_q  <= req_page;
                  off_q   <= req_offset;
                  len_q   <= req_len;
                  buf_q   <= req_buf;
                  err_q   <= 1'b0;
                  cnt_q   <= '0;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD, ST_PROG: begin
               if (byte_done) begin
                  if (hdr_last) begin
                     cnt_q   <= '0;
                     state_q <= (state_q == ST_LOAD) ? ST_GAP_LOAD : ST_GAP_PROG;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_WRITE: begin
               if (byte_done) begin
                  if (write_last) begin
                     cnt_q   <= '0;
                     state_q <= ST_GAP_WRITE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_POLL_LOAD, ST_POLL_PROG: begin
               if (byte_done) begin
                  if (cnt_q == '0) begin
                     cnt_q <= CNT_W'(1);
                  end else if (status_ready) begin
                     cnt_q <= '0;
                     if (state_q == ST_POLL_LOAD) begin
                        state_q <= ST_GAP_POLL;
                     end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  end else if (poll_last) begin
                     cnt_q   <= '0;
                     err_q   <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_GAP_LOAD:  if (gap_last) state_q <= ST_POLL_LOAD;
            ST_GAP_POLL:  if (gap_last) state_q <= ST_WRITE;
            ST_GAP_WRITE: if (gap_last) state_q <= ST_PROG;
            ST_GAP_PROG:  if (gap_last) state_q <= ST_POLL_PROG;
            default:      state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign done        = done_q;
   assign err_timeout = err_q;
   assign din_ready   = data_phase && !inflight_q;
   assign spi_cs_n    = !in_frame;
   assign spi_start   = start_q;
   assign spi_tx      = tx_q;
endmodule

// File: rtl/flash_rmw_seq_chk.sv
module flash_rmw_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic err_timeout,
   input logic din_ready,
   input logic spi_cs_n,
   input logic spi_start,
   input logic spi_done
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= 1'b0;
      else if (spi_start) pend_q <= 1'b1;
      else if (spi_done)  pend_q <= 1'b0;
   end

   assert_start_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |-> !spi_cs_n);

   assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |-> !pend_q);

   assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |=> !spi_start);

   assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |=> spi_cs_n);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spi_cs_n && !busy));

   assert_ready_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      din_ready |-> (!spi_cs_n && busy));

   assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_timeout) |-> (!busy && spi_cs_n && !done));

   assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_cs_n);
endmodule

bind flash_rmw_seq flash_rmw_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .err_timeout (err_timeout),
   .din_ready   (din_ready),
   .spi_cs_n    (spi_cs_n),
   .spi_start   (spi_start),
   .spi_done    (spi_done)
);

// File: tb/test_flash_rmw_seq.sv
module test_flash_rmw_seq;
   localparam int PW  = 11;
   localparam int BW  = 9;
   localparam int PS  = 264;
   localparam int LIM = 8;
   localparam int GAP = 2;
   localparam int LAT = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [PW-1:0] req_page = '0;
   logic [BW-1:0] req_offset = '0;
   logic [BW-1:0] req_len = '0;
   logic          req_buf = 1'b0;
   logic          busy, done, err_timeout, din_ready;
   logic          din_valid = 1'b0;
   logic [7:0]    din_data = '0;
   logic          spi_cs_n, spi_start;
   logic [7:0]    spi_tx;
   logic          spi_done = 1'b0;
   logic [7:0]    spi_rx = '0;

   flash_rmw_seq #(.PAGE_W(PW), .BYTE_W(BW), .POLL_LIMIT(LIM), .GAP_CYCLES(GAP)) i_flash_rmw_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
      .req_offset(req_offset), .req_len(req_len), .req_buf(req_buf),
      .busy(busy), .done(done), .err_timeout(err_timeout),
      .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
      .spi_cs_n(spi_cs_n), .spi_start(spi_start), .spi_tx(spi_tx),
      .spi_done(spi_done), .spi_rx(spi_rx)
   );

   int errors = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // flash model state
   logic [7:0] mem [0:4*PS-1];
   logic [7:0] bufm [0:2*PS-1];
   logic [7:0] fr [0:400];
   int fn = 0;
   int busy_left = 0;
   int busy_set = 0;
   logic prev_cs = 1'b1;
   int lat = 0;
   logic [7:0] pend_resp = '0;
   int frames = 0;
   int step = 0;
   int exp_page = 0, exp_off = 0, exp_len = 0, exp_buf = 0, exp_poll = 0;

   function automatic logic [7:0] dat(input int i);
      return 8'(exp_page * 3 + exp_off + i * 29 + exp_buf * 101);
   endfunction

   function automatic int pbase(input int p);
      return (p & 3) * PS;
   endfunction

   task automatic exec_frame();
      int opc;
      opc = int'(fr[0]);
      frames++;
      case (step)
         0: begin
            chk(opc == (exp_buf ? 8'h55 : 8'h53), "R3 load opcode", opc, exp_buf ? 8'h55 : 8'h53);
            chk(fn == 4 && fr[1] == 8'((exp_page >> 7) & 15) && fr[2] == 8'((exp_page & 127) << 1)
                && fr[3] == 8'h00, "R3 load address bytes", {fr[1], fr[2], fr[3]},
                ((exp_page >> 7) & 15) << 16 | ((exp_page & 127) << 9));
            for (int i = 0; i < PS; i++) bufm[exp_buf*PS + i] = mem[pbase(exp_page) + i];
            busy_left = busy_set;
         end
         1, 4: begin
            chk(opc == 8'h57, "R4 status opcode", opc, 8'h57);
            chk(fn == exp_poll, (exp_poll == LIM + 1) ? "R9 poll length" : "R4 poll length", fn, exp_poll);
         end
         2: begin
            chk(opc == (exp_buf ? 8'h87 : 8'h84), "R5 write opcode", opc, exp_buf ? 8'h87 : 8'h84);
            chk(fn == 4 + exp_len, exp_len == 0 ? "R12 write frame length" : "R5 write frame length",
                fn, 4 + exp_len);
            chk(fr[1] == 8'h00 && fr[2] == 8'((exp_off >> 8) & 1) && fr[3] == 8'(exp_off),
                "R5 write address bytes", {fr[1], fr[2], fr[3]}, exp_off);
            for (int i = 0; i < exp_len; i++) begin
               if (fr[4+i] != dat(i)) chk(0, "R5 data byte order", fr[4+i], dat(i));
               bufm[exp_buf*PS + ((exp_off + i) % PS)] = fr[4+i];
            end
         end
         3: begin
            chk(opc == (exp_buf ? 8'h86 : 8'h83), "R6 program opcode", opc, exp_buf ? 8'h86 : 8'h83);
            chk(fn == 4 && fr[1] == 8'((exp_page >> 7) & 15) && fr[2] == 8'((exp_page & 127) << 1)
                && fr[3] == 8'h00, "R6 program address bytes", {fr[1], fr[2], fr[3]},
                ((exp_page >> 7) & 15) << 16 | ((exp_page & 127) << 9));
            for (int i = 0; i < PS; i++) mem[pbase(exp_page) + i] = bufm[exp_buf*PS + i];
            busy_left = busy_set;
         end
         default: chk(0, "R2 unexpected frame", opc, 0);
      endcase
      step++;
   endtask

   // SPI engine and flash model
   always @(negedge clk) begin
      logic [7:0] resp;
      spi_done = 1'b0;
      if (lat > 0) begin
         lat--;
         if (lat == 0) begin
            spi_done = 1'b1;
            spi_rx = pend_resp;
         end
      end
      if (!spi_cs_n && prev_cs) fn = 0;
      if (spi_start) begin
         fr[fn] = spi_tx;
         resp = 8'hA5;
         if (fr[0] == 8'h57 && fn >= 1) begin
            if (busy_left == 0) resp = 8'h9C;
            else begin
               resp = 8'h1C;
               busy_left--;
            end
         end
         if (fn < 400) fn++;
         pend_resp = resp;
         lat = LAT;
      end
      if (spi_cs_n && !prev_cs) exec_frame();
      prev_cs = spi_cs_n;
   end

   // replacement byte stream
   int sidx = 0;
   int scyc = 0;
   bit stall_mode = 0;
   bit acc_pend = 0;
   always @(negedge clk) begin
      if (acc_pend) sidx++;
      scyc++;
      din_valid = (sidx < exp_len) && (!stall_mode || (scyc % 3) != 0);
      din_data = dat(sidx);
      acc_pend = din_valid && din_ready;
   end

   // done and chip-select gap monitor
   int done_cnt = 0;
   int hi_run = 0;
   int min_gap = 1000;
   always @(negedge clk) begin
      if (done) done_cnt++;
      if (spi_cs_n) hi_run++;
      else begin
         if (hi_run > 0 && step >= 1 && step <= 4 && hi_run < min_gap) min_gap = hi_run;
         hi_run = 0;
      end
   end

   task automatic run_op(input int page, input int off, input int len, input int bsel,
                         input int bsy, input bit stall, input bit poke);
      logic [7:0] exp_pg [0:PS-1];
      logic [7:0] oth [0:PS-1];
      int f0, wait_n, bad, bad2, other;
      bit tmo;
      tmo = (bsy >= LIM);
      other = (page + 1) & 3;
      for (int i = 0; i < PS; i++) begin
         exp_pg[i] = mem[pbase(page) + i];
         oth[i] = mem[other * PS + i];
      end
      exp_page = page; exp_off = off; exp_len = len; exp_buf = bsel;
      exp_poll = tmo ? LIM + 1 : bsy + 2;
      busy_set = bsy;
      for (int i = 0; i < len; i++) if (!tmo) exp_pg[off + i] = dat(i);
      step = 0; sidx = 0; stall_mode = stall; done_cnt = 0; min_gap = 1000;
      f0 = frames;
      @(negedge clk);
      req_valid = 1'b1; req_page = PW'(page); req_offset = BW'(off);
      req_len = BW'(len); req_buf = bsel[0];
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R2 busy after accept", busy, 1);
      if (poke) begin
         repeat (10) @(negedge clk);
         req_valid = 1'b1; req_page = PW'(other); req_offset = '0; req_len = BW'(3);
         repeat (3) @(negedge clk);
         req_valid = 1'b0;
      end
      wait_n = 0;
      while (busy && wait_n < 20000) begin
         @(negedge clk);
         wait_n++;
      end
      chk(wait_n < 20000, "R8 sequence completes", wait_n, 0);
      repeat (4) @(negedge clk);
      if (tmo) begin
         chk(err_timeout == 1'b1, "R9 error flag set", err_timeout, 1);
         chk(done_cnt == 0, "R9 no done on timeout", done_cnt, 0);
         chk(frames - f0 == 2, "R9 frames before abort", frames - f0, 2);
         chk(spi_cs_n == 1'b1 && busy == 1'b0, "R9 back to idle", {spi_cs_n, busy}, 2);
      end else begin
         chk(err_timeout == 1'b0, "R9 error flag clear", err_timeout, 0);
         chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
         chk(frames - f0 == 5, poke ? "R2 ignored request adds no frame" : "R6 frame count",
             frames - f0, 5);
         chk(min_gap >= GAP, "R7 chip-select gap", min_gap, GAP);
      end
      bad = 0; bad2 = 0;
      for (int i = 0; i < PS; i++) begin
         if (mem[pbase(page) + i] != exp_pg[i]) bad++;
         if (mem[other * PS + i] != oth[i]) bad2++;
      end
      chk(bad == 0, len == 0 ? "R12 page unchanged" : "R11 page content", bad, 0);
      chk(bad2 == 0, poke ? "R2 ignored request page untouched" : "R11 other page untouched", bad2, 0);
      if (!tmo) chk(sidx == len, "R5 stream bytes taken", sidx, len);
   endtask

   int pages [5] = '{0, 2047, 1365, 682, 5};
   int offs  [5] = '{0, 100, 263, 7, 255};
   int lens  [5] = '{16, 5, 1, 0, 9};
   int bsys  [5] = '{0, 3, 1, 7, 2};

   initial begin
      for (int i = 0; i < 4 * PS; i++) mem[i] = 8'(i * 13 + 7);
      for (int i = 0; i < 2 * PS; i++) bufm[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1'b1 && spi_start == 1'b0 && busy == 1'b0, "R1 outputs in reset",
          {spi_cs_n, spi_start, busy}, 4);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1'b1 && done == 1'b0 && err_timeout == 1'b0 && din_ready == 1'b0 && busy == 1'b0,
          "R1 idle after reset", {spi_cs_n, done, err_timeout, din_ready, busy}, 16);
      for (int b = 0; b < 2; b++) begin
         for (int k = 0; k < 5; k++) begin
            run_op(pages[k], offs[k], lens[k], b, bsys[k], k[0], 1'b0);
         end
      end
      run_op(77, 20, 30, 1, 2, 1'b0, 1'b1);
      run_op(1000, 40, 4, 0, 100, 1'b0, 1'b0);
      run_op(1000, 40, 4, 0, 1, 1'b0, 1'b0);
      run_op(3, 8, 256, 1, 0, 1'b1, 1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #800000;
      errors++;
      checks++;
      $display("FAIL R8 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule